// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

This block is a synthesizable single-clock synchronous RAM with a flow-through read path and a built-in burst sequencer. A cycle with `burst_next` low and all three chip selects active opens a burst at `addr`. Each later cycle with `burst_next` high steps a 2-bit beat counter over the aligned four-word group, and `burst_ilv` picks the stepping order. Reads and writes can follow each other on consecutive cycles with no idle slot. Read data comes straight out of the array in the cycle after its address edge. Write data is taken one edge after its address, so the bus never needs a turnaround gap.

Each word is 36 bits: four lanes of eight data bits plus one parity bit. Per-lane write strobes merge new data into a word. A write beat with no strobes set writes nothing but still counts as a beat. A held clock edge (`hold`) freezes everything. The tri-state driver is modelled as an enable output (`rdata_drv`) next to a raw read bus. A `sleep` input blanks that enable and drops the current burst.

Top module: `ft_burst_sram`

## Requirements
- R1: After reset no burst is open and `rdata_drv` is 0.
- R2: An edge with `burst_next`=0, `wr`=0 and all chip selects active (`csa_n`=0, `csb`=1, `csc_n`=0) opens a read. In the following cycle `rdata` equals the word at `addr`, and `rdata_drv` is 1 whenever `bus_off`=0 and `sleep`=0.
- R3: With `burst_ilv`=1, beat i of a burst (i = 0..3) addresses the word whose two low address bits are the start value XOR i, with the upper bits unchanged.
- R4: With `burst_ilv`=0, beat i addresses the word whose two low bits are (start + i) mod 4, with the upper bits unchanged.
- R5: A fifth consecutive beat wraps back to the start word of the burst.
- R6: Write data for a beat is sampled on `wdata` at the first enabled edge after that beat's address edge. A read opened at that same edge returns data written by earlier beats with no idle cycle between them.
- R7: `lane_we[i]` gates bits [9i+8:9i] of the word (8 data bits plus parity). Lanes whose strobe is 0 keep their old contents.
- R8: A write beat with `lane_we`=0 leaves memory unchanged, whether it opens a burst or continues one. Such a beat still advances the beat counter.
- R9: An edge with `hold`=1 changes nothing: no address is loaded, no pending write is committed, and `rdata` holds. The pending write is committed, with the `wdata` present then, at the next edge with `hold`=0.
- R10: An opening edge with any chip select inactive closes the burst. `rdata_drv` is then 0, and it stays 0 through the continue cycles that follow.
- R11: `rdata_drv` is 0 while `bus_off`=1 and throughout write beats.
- R12: While `sleep`=1, `rdata_drv` is 0. An edge with `sleep`=1 closes the burst, so `rdata_drv` stays 0 after wake-up until a new burst is opened. Memory contents are retained across sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset of the control state, active low |
| hold | input | 1 | 1 makes the current edge a no-op |
| sleep | input | 1 | Low-power request; blanks the output and closes the burst |
| csa_n | input | 1 | Chip select, active low |
| csb | input | 1 | Chip select, active high |
| csc_n | input | 1 | Chip select, active low |
| burst_next | input | 1 | 0 opens a new burst, 1 continues the current one |
| wr | input | 1 | 1 opens a write burst, 0 a read burst (sampled only when opening) |
| addr | input | ADDR_W | Burst start address |
| lane_we | input | LANES | Per-lane write strobes of the current beat |
| burst_ilv | input | 1 | 1 interleaved beat order, 0 linear order |
| bus_off | input | 1 | 1 disables the output driver |
| wdata | input | DATA_W | Write data bus |
| rdata | output | DATA_W | Flow-through read data |
| rdata_drv | output | 1 | Output driver enable (models the tri-state control) |

## Verification
The bench targets the beat sequence for a start address that is not group-aligned, in both orders and across the wrap. A sequencer that carried into the upper address bits, or that swapped the two orders, would return a word from the wrong group. Held edges are placed in the middle of a read and in the middle of a pending write. Committing the write at the held edge would leave the held-edge data in memory instead of the data presented afterwards. Strobe-free write beats come before a real lane write in the same burst. A counter that skipped an aborted beat would put the lane update on the wrong word. Each chip select and the sleep input are checked separately for closing the burst.

// File: rtl/ft_burst_pkg.sv
package ft_burst_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    // low address bits of a beat, given start bits, beat index and order
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] idx,
        input logic              ilv
    );
        return ilv ? (start ^ idx) : (start + idx);
    endfunction

endpackage

// File: rtl/ft_burst_ctrl.sv
module ft_burst_ctrl
    import ft_burst_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              sleep,
    input  logic              burst_next,
    input  logic              sel_ok,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we,
    output acc_e              acc_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [BEAT_W-1:0] cnt_q,
    output logic [LANES-1:0]  be_q,
    output logic              commit
);

    typedef struct packed {
        acc_e              acc;
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] cnt;
        logic [LANES-1:0]  be;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sleep) begin
            st_d.acc = ACC_IDLE;
        end else if (!hold) begin
            if (!burst_next) begin
                if (sel_ok) begin
                    st_d.acc  = wr ? ACC_WRITE : ACC_READ;
                    st_d.base = addr;
                    st_d.cnt  = '0;
                    st_d.be   = wr ? lane_we : '0;
                end else begin
                    st_d.acc = ACC_IDLE;
                end
            end else if (st_q.acc != ACC_IDLE) begin
                st_d.cnt = st_q.cnt + BEAT_W'(1);
                st_d.be  = (st_q.acc == ACC_WRITE) ? lane_we : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_q  = st_q.acc;
    assign base_q = st_q.base;
    assign cnt_q  = st_q.cnt;
    assign be_q   = st_q.be;
    // the open write beat completes at the next enabled, awake edge
    assign commit = (st_q.acc == ACC_WRITE) && !hold && !sleep;

endmodule

// File: rtl/ft_burst_addr.sv
module ft_burst_addr
    import ft_burst_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [BEAT_W-1:0] cnt,
    input  logic              ilv,
    output logic [ADDR_W-1:0] cur
);

    logic [BEAT_W-1:0] low;

    assign low = beat_offset(base[BEAT_W-1:0], cnt, ilv);
    assign cur = {base[ADDR_W-1:BEAT_W], low};

endmodule

// File: rtl/ft_lane_ram.sv
module ft_lane_ram #(
    parameter int DEPTH  = 64,
    parameter int LANE_W = 9,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/ft_burst_sram.sv
module ft_burst_sram
    import ft_burst_pkg::*;
#(
    parameter  int DEPTH  = 64,
    parameter  int LANES  = 4,
    parameter  int LANE_W = 9,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              sleep,
    input  logic              csa_n,
    input  logic              csb,
    input  logic              csc_n,
    input  logic              burst_next,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we,
    input  logic              burst_ilv,
    input  logic              bus_off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drv
);

    logic              sel_ok;
    acc_e              acc_q;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [LANES-1:0]  be_q;
    logic              commit;
    logic [ADDR_W-1:0] cur;

    assign sel_ok = !csa_n && csb && !csc_n;

    ft_burst_ctrl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold),
        .sleep      (sleep),
        .burst_next (burst_next),
        .sel_ok     (sel_ok),
        .wr         (wr),
        .addr       (addr),
        .lane_we    (lane_we),
        .acc_q      (acc_q),
        .base_q     (base_q),
        .cnt_q      (cnt_q),
        .be_q       (be_q),
        .commit     (commit)
    );

    ft_burst_addr #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .base (base_q),
        .cnt  (cnt_q),
        .ilv  (burst_ilv),
        .cur  (cur)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        ft_lane_ram #(
            .DEPTH  (DEPTH),
            .LANE_W (LANE_W),
            .ADDR_W (ADDR_W)
        ) u_lane (
            .clk   (clk),
            .we    (commit && be_q[i]),
            .addr  (cur),
            .wdata (wdata[i*LANE_W +: LANE_W]),
            .rdata (rdata[i*LANE_W +: LANE_W])
        );
    end

    assign rdata_drv = (acc_q == ACC_READ) && !bus_off && !sleep;

endmodule

// File: rtl/ft_burst_sram_chk.sv
module ft_burst_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              sleep,
    input logic              csa_n,
    input logic              csb,
    input logic              csc_n,
    input logic              burst_next,
    input logic              wr,
    input logic              bus_off,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_drv
);

    logic open_edge;
    logic all_sel;

    assign open_edge = !hold && !sleep && !burst_next;
    assign all_sel   = !csa_n && csb && !csc_n;

    // R12
    sleep_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdata_drv);

    // R11
    bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off |-> !rdata_drv);

    // R11
    write_beat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_edge && all_sel && wr) |=> !rdata_drv);

    // R10
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_edge && !all_sel) |=> !rdata_drv);

    // R9
    hold_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !sleep) |=> $stable(rdata));

    // R2
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(open_edge && all_sel && !wr) && !bus_off && !sleep)
        |-> rdata_drv);

endmodule

bind ft_burst_sram ft_burst_sram_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .sleep      (sleep),
    .csa_n      (csa_n),
    .csb        (csb),
    .csc_n      (csc_n),
    .burst_next (burst_next),
    .wr         (wr),
    .bus_off    (bus_off),
    .rdata      (rdata),
    .rdata_drv  (rdata_drv)
);

// File: tb/ft_burst_sram_tb.sv
module ft_burst_sram_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        hold = 1'b0, sleep = 1'b0;
    logic        csa_n = 1'b0, csb = 1'b1, csc_n = 1'b0;
    logic        burst_next = 1'b1, wr = 1'b0, burst_ilv = 1'b1, bus_off = 1'b0;
    logic [5:0]  addr = '0;
    logic [3:0]  lane_we = '0;
    logic [35:0] wdata = '0;
    logic [35:0] rdata;
    logic        rdata_drv;

    ft_burst_sram u_dut (
        .clk(clk), .rst_n(rst_n), .hold(hold), .sleep(sleep),
        .csa_n(csa_n), .csb(csb), .csc_n(csc_n),
        .burst_next(burst_next), .wr(wr), .addr(addr), .lane_we(lane_we),
        .burst_ilv(burst_ilv), .bus_off(bus_off), .wdata(wdata),
        .rdata(rdata), .rdata_drv(rdata_drv)
    );

    typedef struct packed {
        logic        c_dat;
        logic        e_drv;
        logic [35:0] e_dat;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;

    logic [35:0] ref_mem [64];
    logic        g_hold = 1'b0, g_zz = 1'b0, g_off = 1'b0, g_ilv = 1'b1;
    logic [2:0]  g_dsel = 3'b000;
    localparam logic [35:0] ONES = '1;

    function automatic logic [35:0] pat(input int a);
        logic [5:0] s;
        s = a[5:0];
        return {3'd3, s, 3'd2, s, 3'd1, s, 3'd0, s};
    endfunction

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                          input logic [3:0] be);
        logic [35:0] r;
        r = old;
        for (int i = 0; i < 4; i++) if (be[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    // driver: one bus cycle, plus the expectation for the cycle after its edge
    task automatic cyc(input logic nxt, input logic w, input int a, input logic [3:0] be,
                       input logic [35:0] d, input logic cd, input logic edrv,
                       input logic [35:0] ed, input string tag);
        exp_t e;
        @(negedge clk);
        burst_next = nxt; wr = w; addr = a[5:0]; lane_we = be; wdata = d;
        hold = g_hold; sleep = g_zz; bus_off = g_off; burst_ilv = g_ilv;
        csa_n = g_dsel[0]; csb = ~g_dsel[1]; csc_n = g_dsel[2];
        e.c_dat = cd; e.e_drv = edrv; e.e_dat = ed;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic ld_rd(input int a, input logic [35:0] d, input string tag);
        cyc(1'b0, 1'b0, a, 4'h0, d, 1'b1, 1'b1, ref_mem[a], tag);
    endtask

    task automatic ld_wr(input int a, input logic [3:0] be, input logic [35:0] d, input string tag);
        cyc(1'b0, 1'b1, a, be, d, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic nx_rd(input int a, input string tag);
        cyc(1'b1, 1'b0, 0, 4'h0, '0, 1'b1, 1'b1, ref_mem[a], tag);
    endtask

    task automatic nx_wr(input logic [3:0] be, input logic [35:0] d, input string tag);
        cyc(1'b1, 1'b1, 0, be, d, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // monitor: compares outputs mid-cycle after each edge
    initial begin
        exp_t  e;
        string t;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (rdata_drv !== e.e_drv) begin
                    n_bad++;
                    $display("FAIL %s: rdata_drv actual %b expected %b", t, rdata_drv, e.e_drv);
                end
                if (e.c_dat) begin
                    n_chk++;
                    if (rdata !== e.e_dat) begin
                        n_bad++;
                        $display("FAIL %s: rdata actual %h expected %h", t, rdata, e.e_dat);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset
        cyc(1'b1, 1'b0, 0, 4'h0, '0, 1'b0, 1'b0, '0, "R1");

        // fill words 0..11 with back-to-back linear write bursts (R11: no drive)
        g_ilv = 1'b0;
        for (int w = 0; w < 12; w++) begin
            if (w % 4 == 0) ld_wr(w, 4'hF, (w == 0) ? 36'h0 : pat(w - 1), "R11");
            else            nx_wr(4'hF, pat(w - 1), "R11");
        end
        for (int w = 0; w < 12; w++) ref_mem[w] = pat(w);
        // R6 R2: read right behind the last write beat
        ld_rd(8, pat(11), "R6");

        // R3 R5: interleaved from 9 -> 9,8,11,10, wrap to 9
        g_ilv = 1'b1;
        ld_rd(9, '0, "R2");
        nx_rd(8, "R3");
        nx_rd(11, "R3");
        nx_rd(10, "R3");
        nx_rd(9, "R5");

        // R4 R5: linear from 9 -> 9,10,11,8, wrap to 9
        g_ilv = 1'b0;
        ld_rd(9, '0, "R4");
        nx_rd(10, "R4");
        nx_rd(11, "R4");
        nx_rd(8, "R4");
        nx_rd(9, "R5");

        // R7: lanes 0 and 2 of word 2
        g_ilv = 1'b1;
        ld_wr(2, 4'b0101, '0, "R7");
        ref_mem[2] = merge(ref_mem[2], ONES, 4'b0101);
        ld_rd(2, ONES, "R7");

        // R8: aborted beats at 3 and 2, then lane 3 written at 1
        ld_wr(3, 4'b0000, '0, "R8");
        nx_wr(4'b0000, ONES, "R8");
        nx_wr(4'b1000, ONES, "R8");
        ref_mem[1] = merge(ref_mem[1], ONES, 4'b1000);
        ld_rd(3, ONES, "R8");
        nx_rd(2, "R8");
        nx_rd(1, "R8");
        nx_rd(0, "R8");

        // R9: held edge during a read, with an ignored load attempt
        ld_rd(4, '0, "R9");
        g_hold = 1'b1;
        cyc(1'b0, 1'b0, 0, 4'h0, '0, 1'b1, 1'b1, ref_mem[4], "R9");
        g_hold = 1'b0;
        nx_rd(5, "R9");
        // R9: held edge with a write pending
        ld_wr(6, 4'hF, '0, "R9");
        g_hold = 1'b1;
        cyc(1'b1, 1'b1, 0, 4'hF, ONES, 1'b0, 1'b0, '0, "R9");
        g_hold = 1'b0;
        ref_mem[6] = 36'h123456789;
        ld_rd(6, 36'h123456789, "R9");

        // R10: each chip select closes the burst
        ld_rd(5, '0, "R10");
        g_dsel = 3'b010;
        cyc(1'b0, 1'b0, 5, 4'h0, '0, 1'b0, 1'b0, '0, "R10");
        g_dsel = 3'b000;
        cyc(1'b1, 1'b0, 0, 4'h0, '0, 1'b0, 1'b0, '0, "R10");
        ld_rd(5, '0, "R10");
        g_dsel = 3'b001;
        cyc(1'b0, 1'b0, 5, 4'h0, '0, 1'b0, 1'b0, '0, "R10");
        g_dsel = 3'b000;
        ld_rd(5, '0, "R10");
        g_dsel = 3'b100;
        cyc(1'b0, 1'b0, 5, 4'h0, '0, 1'b0, 1'b0, '0, "R10");
        g_dsel = 3'b000;

        // R11: bus_off blanks the driver but not the raw data
        g_off = 1'b1;
        cyc(1'b0, 1'b0, 4, 4'h0, '0, 1'b1, 1'b0, ref_mem[4], "R11");
        g_off = 1'b0;
        nx_rd(5, "R11");

        // R12: sleep blanks, closes the burst, keeps memory
        ld_rd(4, '0, "R12");
        g_zz = 1'b1;
        cyc(1'b1, 1'b0, 0, 4'h0, '0, 1'b0, 1'b0, '0, "R12");
        cyc(1'b1, 1'b0, 0, 4'h0, '0, 1'b0, 1'b0, '0, "R12");
        g_zz = 1'b0;
        cyc(1'b1, 1'b0, 0, 4'h0, '0, 1'b0, 1'b0, '0, "R12");
        ld_rd(0, '0, "R12");

        repeat (2) @(posedge clk);
        #3;
        summary();
        $finish;
    end

endmodule